// File: doc/BRIEF.md
# Compact-to-Wide Instruction Expander

This block turns one 16-bit compact instruction into the equivalent 32-bit base-ISA instruction word. The five most significant bits of the compact word pick an instruction format. Each format has a fixed base pattern. The register numbers, immediates and masks of the compact word are then copied, and where needed scaled, into fixed fields of that pattern. Every word the block produces carries the always-execute condition 0xE in bits [31:28].

A status output reports one of three results. The first is a decoded word. The second is an undefined encoding. The third is a branch, which a separate branch unit must handle. In the last two cases the wide word is forced to zero, so downstream logic can ignore it.

By default the result is captured in an output register with a valid flag, one cycle after the input. While the input is idle, the register keeps its previous contents. A parameter can remove the register and make the path purely combinational.

Top module: `narrow_to_wide_expander`

## Requirements
- R1: Status is 0 (decoded), 1 (undefined) or 2 (branch), never 3. The format field is in_half[15:11]. Formats 28, 30 and 31 report branch, and format 29 reports undefined. In formats 26 and 27, the condition field [11:8] decides: 0xF is a software interrupt, 0xE is undefined, and every other value is a branch.
- R2: A non-decoded result always has out_word equal to zero. Every decoded word has 0xE in [31:28].
- R3: Formats 0 to 2 (shift by immediate) give 0xE1B00000, with in[12:11] placed at [6:5], in[10:6] at [11:7], in[5:3] at [2:0] and in[2:0] at [14:12].
- R4: Format 3 takes its base from in[10:9]: 0 gives 0xE0900000, 1 gives 0xE0500000, 2 gives 0xE2900000 and 3 gives 0xE2500000. It places in[8:6] at [2:0], in[5:3] at [18:16] and in[2:0] at [14:12].
- R5: Formats 4 to 7 take their base from in[12:11]: 0 gives 0xE3B00000, 1 gives 0xE3500000, 2 gives 0xE2900000 and 3 gives 0xE2500000. They copy in[7:0] to [7:0], and copy in[10:8] to both [18:16] and [14:12].
- R6: Format 8 with in[10]=0 selects one of 16 register operations by in[9:6]. Operand placement depends on the operation:
  - Ordinary operations put d=in[2:0] at [18:16] and [14:12], and s=in[5:3] at [2:0].
  - The shift operations (2, 3, 4, 7) put d at [14:12] and [2:0], and s at [11:8].
  - Operation 9 becomes 0xE2700000, with d at [14:12] and s at [18:16].
  - Operation 13 becomes 0xE0100090, with d at [18:16] and [11:8], and s at [2:0].
- R7: Format 8 with in[10]=1 widens the register numbers to D={in[7],in[2:0]} and S=in[6:3].
  - Operations 1 to 3 use base 0xE0800000, operations 5 to 7 use 0xE1500000, and operations 9 to 11 use 0xE1A00000. Each puts D at [19:16] and [15:12], and S at [3:0].
  - Operations 12 and 13 give 0xE12FFF10 with in[6:3] at [3:0].
  - Operations 0, 4, 8, 14 and 15 are undefined.
- R8: Format 9 gives 0xE59F0000, with in[10:8] at [14:12] and in[7:0] shifted left by 2. Formats 10 and 11 place in[2:0] at [14:12], in[5:3] at [18:16] and in[8:6] at [2:0]. Their base is chosen by in[9] and in[11:10]:
  - With in[9]=0 the bases are 0xE7800000, 0xE7C00000, 0xE7900000 and 0xE7D00000.
  - With in[9]=1 they are 0xE18000B0, 0xE19000D0, 0xE19000B0 and 0xE19000F0.
- R9: Formats 12 to 15 take their base from in[12:11]: 0 gives 0xE5800000, 1 gives 0xE5900000, 2 gives 0xE5C00000 and 3 gives 0xE5D00000. The 5-bit offset in[10:6] is multiplied by 4 when in[12]=0 and used unscaled when in[12]=1. Formats 16 and 17 use 0xE1C000B0 for a store and 0xE1D000B0 for a load (in[11]). Their offset is doubled, with the low nibble at [3:0] and the upper bits at [11:8]. In both groups, in[2:0] goes to [14:12] and in[5:3] to [18:16].
- R10: Formats 18 and 19 give 0xE58D0000 for a store and 0xE59D0000 for a load, with in[10:8] at [14:12] and in[7:0] shifted left by 2. Formats 20 and 21 give 0xE28F0F00 when in[11]=0 and 0xE28D0F00 when in[11]=1, with in[10:8] at [14:12] and in[7:0] unshifted at [7:0]. Formats 22 and 23 with in[11:8]=0 give 0xE28DDF00, or 0xE24DDF00 when in[7]=1, with in[6:0] at [6:0].
- R11: Formats 22 and 23 with in[11:8]≠0 pick their base from {in[11],in[8]}: 0 gives 0xE92D0000, 1 gives 0xE92D4000, 2 gives 0xE8BD0000 and 3 gives 0xE8BD8000. In formats 24 and 25 the base is 0xE8B00000 when in[11]=1 and 0xE8A00000 otherwise, with in[10:8] at [18:16]. Both groups copy in[7:0] to [7:0].
- R12: The software interrupt gives 0xEF000000 with in[7:0] at [7:0], except that the value 0x18 is placed at [23:16] instead.
- R13: With the output register on, reset clears out_valid, out_word and out_status. A result appears on the outputs one cycle after a valid input, and out_valid follows in_valid with that delay. A cycle with in_valid low leaves out_word and out_status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The compact word on in_half is to be translated |
| in_half | input | 16 | Compact instruction word |
| out_valid | output | 1 | Outputs hold a fresh translation |
| out_word | output | 32 | Wide instruction word, zero unless decoded |
| out_status | output | 2 | 0 decoded, 1 undefined, 2 branch |

## Verification
The assertions assume that in_valid and the upper byte of in_half are known at every clock edge once reset is released. They also assume that reset is held for at least one edge before the first valid input, so the hold-when-idle and latency properties start from the cleared register. The bench meets these assumptions by driving every input from a defined value on the falling edge and holding reset for two edges. It then sweeps every format code, every register-operation and high-register code, and every condition value. Random words follow, with in_valid toggled at random so that hold cycles interleave with new results.

// File: rtl/nwx_pkg.sv
package nwx_pkg;

    localparam int NARROW_W = 16;
    localparam int WIDE_W   = 32;
    localparam int CODE_W   = 5;
    localparam int CODE_LSB = NARROW_W - CODE_W;

    typedef enum logic [1:0] {
        XS_DECODED = 2'd0,
        XS_UNDEF   = 2'd1,
        XS_BRANCH  = 2'd2
    } xstat_e;

    typedef struct packed {
        logic [WIDE_W-1:0] word;
        xstat_e            stat;
    } xres_t;

    typedef enum logic [1:0] {
        OPK_DYADIC,
        OPK_SHIFTREG,
        OPK_NEGATE,
        OPK_MULT
    } opk_e;

    typedef struct packed {
        logic [WIDE_W-1:0] base;
        opk_e              kind;
    } regop_ent_t;

    function automatic xres_t mk_ok(input logic [WIDE_W-1:0] w);
        xres_t r;
        r.word = w;
        r.stat = XS_DECODED;
        return r;
    endfunction

    function automatic xres_t mk_stat(input xstat_e s);
        xres_t r;
        r.word = '0;
        r.stat = s;
        return r;
    endfunction

    // sixteen register-to-register operations, indexed by the op field
    function automatic regop_ent_t regop_lookup(input logic [3:0] op);
        regop_ent_t e;
        e.kind = OPK_DYADIC;
        unique case (op)
            4'd0:  e.base = 32'hE010_0000;
            4'd1:  e.base = 32'hE030_0000;
            4'd2:  begin e.base = 32'hE1B0_0010; e.kind = OPK_SHIFTREG; end
            4'd3:  begin e.base = 32'hE1B0_0030; e.kind = OPK_SHIFTREG; end
            4'd4:  begin e.base = 32'hE1B0_0050; e.kind = OPK_SHIFTREG; end
            4'd5:  e.base = 32'hE0B0_0000;
            4'd6:  e.base = 32'hE0D0_0000;
            4'd7:  begin e.base = 32'hE1B0_0070; e.kind = OPK_SHIFTREG; end
            4'd8:  e.base = 32'hE110_0000;
            4'd9:  begin e.base = 32'hE270_0000; e.kind = OPK_NEGATE; end
            4'd10: e.base = 32'hE150_0000;
            4'd11: e.base = 32'hE170_0000;
            4'd12: e.base = 32'hE190_0000;
            4'd13: begin e.base = 32'hE010_0090; e.kind = OPK_MULT; end
            4'd14: e.base = 32'hE1D0_0000;
            default: e.base = 32'hE1F0_0000;
        endcase
        return e;
    endfunction

    // register-offset transfers: ext selects the halfword/signed group
    function automatic logic [WIDE_W-1:0] regofs_base(input logic ext, input logic [1:0] op);
        logic [WIDE_W-1:0] b;
        unique case ({ext, op})
            3'b000:  b = 32'hE780_0000;
            3'b001:  b = 32'hE7C0_0000;
            3'b010:  b = 32'hE790_0000;
            3'b011:  b = 32'hE7D0_0000;
            3'b100:  b = 32'hE180_00B0;
            3'b101:  b = 32'hE190_00D0;
            3'b110:  b = 32'hE190_00B0;
            default: b = 32'hE190_00F0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/nwx_arith_dec.sv
module nwx_arith_dec
    import nwx_pkg::*;
(
    input  logic [NARROW_W-1:0] half,
    output xres_t               res
);
    logic [CODE_W-1:0] code;
    logic [WIDE_W-1:0] w;

    always_comb begin
        code = half[NARROW_W-1 -: CODE_W];
        w    = '0;
        if (code < 5'd3) begin
            // shift by immediate
            w         = 32'hE1B0_0000;
            w[6:5]    = half[12:11];
            w[11:7]   = half[10:6];
            w[2:0]    = half[5:3];
            w[14:12]  = half[2:0];
        end else if (code == 5'd3) begin
            // three-operand add/subtract
            unique case (half[10:9])
                2'd0:    w = 32'hE090_0000;
                2'd1:    w = 32'hE050_0000;
                2'd2:    w = 32'hE290_0000;
                default: w = 32'hE250_0000;
            endcase
            w[2:0]   = half[8:6];
            w[18:16] = half[5:3];
            w[14:12] = half[2:0];
        end else begin
            // move/compare/add/subtract with 8-bit immediate
            unique case (half[12:11])
                2'd0:    w = 32'hE3B0_0000;
                2'd1:    w = 32'hE350_0000;
                2'd2:    w = 32'hE290_0000;
                default: w = 32'hE250_0000;
            endcase
            w[7:0]   = half[7:0];
            w[18:16] = half[10:8];
            w[14:12] = half[10:8];
        end
        res = mk_ok(w);
    end
endmodule

// File: rtl/nwx_regop_dec.sv
module nwx_regop_dec
    import nwx_pkg::*;
(
    input  logic [10:0] ops,
    output xres_t       res
);
    regop_ent_t        ent;
    logic [3:0]        op;
    logic [3:0]        hd;
    logic [3:0]        hs;
    logic [WIDE_W-1:0] w;

    always_comb begin
        op  = ops[9:6];
        hd  = {ops[7], ops[2:0]};
        hs  = ops[6:3];
        ent = regop_lookup(op);
        w   = '0;
        res = mk_stat(XS_UNDEF);
        if (!ops[10]) begin
            w = ent.base;
            unique case (ent.kind)
                OPK_SHIFTREG: begin
                    w[14:12] = ops[2:0];
                    w[2:0]   = ops[2:0];
                    w[10:8]  = ops[5:3];
                end
                OPK_NEGATE: begin
                    w[14:12] = ops[2:0];
                    w[18:16] = ops[5:3];
                end
                OPK_MULT: begin
                    w[18:16] = ops[2:0];
                    w[10:8]  = ops[2:0];
                    w[2:0]   = ops[5:3];
                end
                default: begin
                    w[18:16] = ops[2:0];
                    w[14:12] = ops[2:0];
                    w[2:0]   = ops[5:3];
                end
            endcase
            res = mk_ok(w);
        end else begin
            unique case (op)
                4'd1, 4'd2, 4'd3:   w = 32'hE080_0000;
                4'd5, 4'd6, 4'd7:   w = 32'hE150_0000;
                4'd9, 4'd10, 4'd11: w = 32'hE1A0_0000;
                4'd12, 4'd13:       w = 32'hE12F_FF10;
                default:            w = '0;
            endcase
            if (op == 4'd12 || op == 4'd13) begin
                w[3:0] = ops[6:3];
                res    = mk_ok(w);
            end else if (w != '0) begin
                w[19:16] = hd;
                w[15:12] = hd;
                w[3:0]   = hs;
                res      = mk_ok(w);
            end
        end
    end
endmodule

// File: rtl/nwx_mem_dec.sv
module nwx_mem_dec
    import nwx_pkg::*;
(
    input  logic [NARROW_W-1:0] half,
    output xres_t               res
);
    logic [CODE_W-1:0] code;
    logic [WIDE_W-1:0] w;

    always_comb begin
        code = half[NARROW_W-1 -: CODE_W];
        w    = '0;
        if (code == 5'd9) begin
            // load relative to program counter, word offset
            w        = 32'hE59F_0000;
            w[14:12] = half[10:8];
            w[9:2]   = half[7:0];
        end else if (code <= 5'd11) begin
            w        = regofs_base(half[9], half[11:10]);
            w[14:12] = half[2:0];
            w[18:16] = half[5:3];
            w[2:0]   = half[8:6];
        end else if (code <= 5'd15) begin
            unique case (half[12:11])
                2'd0:    w = 32'hE580_0000;
                2'd1:    w = 32'hE590_0000;
                2'd2:    w = 32'hE5C0_0000;
                default: w = 32'hE5D0_0000;
            endcase
            w[14:12] = half[2:0];
            w[18:16] = half[5:3];
            if (half[12]) w[4:0] = half[10:6];
            else          w[6:2] = half[10:6];
        end else if (code <= 5'd17) begin
            w        = half[11] ? 32'hE1D0_00B0 : 32'hE1C0_00B0;
            w[14:12] = half[2:0];
            w[18:16] = half[5:3];
            w[3:1]   = half[8:6];
            w[9:8]   = half[10:9];
        end else if (code <= 5'd19) begin
            w        = half[11] ? 32'hE59D_0000 : 32'hE58D_0000;
            w[14:12] = half[10:8];
            w[9:2]   = half[7:0];
        end else begin
            // rotate field 0xF supplies the times-four scaling
            w        = half[11] ? 32'hE28D_0F00 : 32'hE28F_0F00;
            w[14:12] = half[10:8];
            w[7:0]   = half[7:0];
        end
        res = mk_ok(w);
    end
endmodule

// File: rtl/nwx_ctrl_dec.sv
module nwx_ctrl_dec
    import nwx_pkg::*;
(
    input  logic [NARROW_W-1:0] half,
    output xres_t               res
);
    localparam logic [7:0] TRAP_SPECIAL = 8'h18;

    logic [CODE_W-1:0] code;
    logic [3:0]        cond;
    logic [WIDE_W-1:0] w;

    always_comb begin
        code = half[NARROW_W-1 -: CODE_W];
        cond = half[11:8];
        w    = '0;
        res  = mk_stat(XS_BRANCH);
        if (code <= 5'd23) begin
            if (cond == 4'd0) begin
                w      = half[7] ? 32'hE24D_DF00 : 32'hE28D_DF00;
                w[6:0] = half[6:0];
            end else begin
                unique case ({half[11], half[8]})
                    2'd0:    w = 32'hE92D_0000;
                    2'd1:    w = 32'hE92D_4000;
                    2'd2:    w = 32'hE8BD_0000;
                    default: w = 32'hE8BD_8000;
                endcase
                w[7:0] = half[7:0];
            end
            res = mk_ok(w);
        end else if (code <= 5'd25) begin
            w        = half[11] ? 32'hE8B0_0000 : 32'hE8A0_0000;
            w[18:16] = half[10:8];
            w[7:0]   = half[7:0];
            res      = mk_ok(w);
        end else if (code <= 5'd27) begin
            if (cond == 4'hF) begin
                w = 32'hEF00_0000;
                if (half[7:0] == TRAP_SPECIAL) w[23:16] = half[7:0];
                else                           w[7:0]   = half[7:0];
                res = mk_ok(w);
            end else if (cond == 4'hE) begin
                res = mk_stat(XS_UNDEF);
            end
        end else if (code == 5'd29) begin
            res = mk_stat(XS_UNDEF);
        end
    end
endmodule

// File: rtl/narrow_to_wide_expander.sv
module narrow_to_wide_expander
    import nwx_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [NARROW_W-1:0] in_half,
    output logic                out_valid,
    output logic [WIDE_W-1:0]   out_word,
    output logic [1:0]          out_status
);
    logic [CODE_W-1:0] code;
    xres_t res_arith, res_regop, res_mem, res_ctrl;
    xres_t res_sel, res_fin;

    assign code = in_half[NARROW_W-1 -: CODE_W];

    nwx_arith_dec u_arith (.half(in_half),       .res(res_arith));
    nwx_regop_dec u_regop (.ops(in_half[10:0]),  .res(res_regop));
    nwx_mem_dec   u_mem   (.half(in_half),       .res(res_mem));
    nwx_ctrl_dec  u_ctrl  (.half(in_half),       .res(res_ctrl));

    always_comb begin
        if (code < 5'd8)        res_sel = res_arith;
        else if (code == 5'd8)  res_sel = res_regop;
        else if (code <= 5'd21) res_sel = res_mem;
        else                    res_sel = res_ctrl;
        // single zeroing point for every non-decoded result
        res_fin = res_sel;
        if (res_sel.stat != XS_DECODED) res_fin.word = '0;
    end

    generate
        if (REGISTER_OUT) begin : g_reg
            logic              vld_q;
            logic [WIDE_W-1:0] word_q;
            xstat_e            stat_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q  <= 1'b0;
                    word_q <= '0;
                    stat_q <= XS_DECODED;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) begin
                        word_q <= res_fin.word;
                        stat_q <= res_fin.stat;
                    end
                end
            end
            assign out_valid  = vld_q;
            assign out_word   = word_q;
            assign out_status = stat_q;
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_word   = res_fin.word;
            assign out_status = res_fin.stat;
        end
    endgenerate
endmodule

// File: rtl/nwx_checker.sv
module nwx_checker #(
    parameter bit REGISTER_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [7:0]  in_hi,
    input logic        out_valid,
    input logic [31:0] out_word,
    input logic [1:0]  out_status
);
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_status != 2'd3); // R1
    AST_NONDECODED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_status != 2'd0) |-> out_word == 32'h0); // R2
    AST_COND_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_status == 2'd0) |-> out_word[31:28] == 4'hE); // R2

    generate
        if (REGISTER_OUT) begin : g_seq
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid); // R13
            AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid); // R13
            AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(out_word) && $stable(out_status))); // R13
            AST_UNCOND_BRANCH: assert property (@(posedge clk) disable iff (rst)
                (in_valid && (in_hi[7:3] == 5'd28 || in_hi[7:3] == 5'd30 || in_hi[7:3] == 5'd31))
                |=> out_status == 2'd2); // R1
            AST_TRAP_DECODED: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_hi == 8'hDF) |=> (out_status == 2'd0 && out_word[27:24] == 4'hF)); // R12
        end
    endgenerate
endmodule

bind narrow_to_wide_expander nwx_checker #(.REGISTER_OUT(REGISTER_OUT)) u_chk (
    .clk(clk),
    .rst(rst),
    .in_valid(in_valid),
    .in_hi(in_half[15:8]),
    .out_valid(out_valid),
    .out_word(out_word),
    .out_status(out_status)
);

// File: tb/tb_narrow_to_wide_expander.sv
module tb_narrow_to_wide_expander;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_half;
    logic        out_valid;
    logic [31:0] out_word;
    logic [1:0]  out_status;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic        v;
        logic [31:0] w;
        logic [1:0]  s;
        logic [15:0] h;
        string       tag;
    } exp_t;

    exp_t        pend[$];
    logic [31:0] hold_w = 32'h0;
    logic [1:0]  hold_s = 2'd0;

    always #5 clk = ~clk;

    narrow_to_wide_expander dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
        .out_valid(out_valid), .out_word(out_word), .out_status(out_status)
    );

    // behavioural model of the requirements
    function automatic void ref_model(input logic [15:0] h, output logic [31:0] w,
                                      output logic [1:0] st, output string tag);
        int unsigned code = h >> 11;
        int unsigned lo3  = h & 7;
        int unsigned mid3 = (h >> 3) & 7;
        int unsigned r86  = (h >> 6) & 7;
        int unsigned r108 = (h >> 8) & 7;
        int unsigned i8   = h & 255;
        int unsigned i5   = (h >> 6) & 31;
        int unsigned op   = (h >> 6) & 15;
        int unsigned cc   = (h >> 8) & 15;
        logic [31:0] as_b [4]  = '{32'hE0900000, 32'hE0500000, 32'hE2900000, 32'hE2500000};
        logic [31:0] im_b [4]  = '{32'hE3B00000, 32'hE3500000, 32'hE2900000, 32'hE2500000};
        logic [31:0] alu_b [16] = '{32'hE0100000, 32'hE0300000, 32'hE1B00010, 32'hE1B00030,
                                    32'hE1B00050, 32'hE0B00000, 32'hE0D00000, 32'hE1B00070,
                                    32'hE1100000, 32'hE2700000, 32'hE1500000, 32'hE1700000,
                                    32'hE1900000, 32'hE0100090, 32'hE1D00000, 32'hE1F00000};
        logic [31:0] ro_b [8]  = '{32'hE7800000, 32'hE7C00000, 32'hE7900000, 32'hE7D00000,
                                   32'hE18000B0, 32'hE19000D0, 32'hE19000B0, 32'hE19000F0};
        logic [31:0] i5_b [4]  = '{32'hE5800000, 32'hE5900000, 32'hE5C00000, 32'hE5D00000};
        logic [31:0] pp_b [4]  = '{32'hE92D0000, 32'hE92D4000, 32'hE8BD0000, 32'hE8BD8000};
        int unsigned hd, hs, h2;
        w = 32'h0; st = 2'd0; tag = "R1";
        if (code < 3) begin
            tag = "R3";
            w = 32'hE1B00000 | (((h >> 11) & 3) << 5) | (i5 << 7) | mid3 | (lo3 << 12);
        end else if (code == 3) begin
            tag = "R4";
            w = as_b[(h >> 9) & 3] | r86 | (mid3 << 16) | (lo3 << 12);
        end else if (code < 8) begin
            tag = "R5";
            w = im_b[(h >> 11) & 3] | i8 | (r108 << 16) | (r108 << 12);
        end else if (code == 8 && ((h >> 10) & 1) == 0) begin
            tag = "R6";
            w = alu_b[op];
            if (op == 2 || op == 3 || op == 4 || op == 7) w |= (lo3 << 12) | lo3 | (mid3 << 8);
            else if (op == 9)  w |= (lo3 << 12) | (mid3 << 16);
            else if (op == 13) w |= (lo3 << 16) | (lo3 << 8) | mid3;
            else               w |= (lo3 << 16) | (lo3 << 12) | mid3;
        end else if (code == 8) begin
            tag = "R7";
            hd = ((h >> 4) & 8) | lo3;
            hs = (h >> 3) & 15;
            if (op >= 1 && op <= 3)       w = 32'hE0800000 | (hd << 16) | (hd << 12) | hs;
            else if (op >= 5 && op <= 7)  w = 32'hE1500000 | (hd << 16) | (hd << 12) | hs;
            else if (op >= 9 && op <= 11) w = 32'hE1A00000 | (hd << 16) | (hd << 12) | hs;
            else if (op == 12 || op == 13) w = 32'hE12FFF10 | hs;
            else st = 2'd1;
        end else if (code == 9) begin
            tag = "R8";
            w = 32'hE59F0000 | (r108 << 12) | (i8 << 2);
        end else if (code <= 11) begin
            tag = "R8";
            w = ro_b[(((h >> 9) & 1) << 2) | ((h >> 10) & 3)] | (lo3 << 12) | (mid3 << 16) | r86;
        end else if (code <= 15) begin
            tag = "R9";
            w = i5_b[(h >> 11) & 3] | (lo3 << 12) | (mid3 << 16) | (((h >> 12) & 1) ? i5 : i5 * 4);
        end else if (code <= 17) begin
            tag = "R9";
            h2 = i5 * 2;
            w = (((h >> 11) & 1) ? 32'hE1D000B0 : 32'hE1C000B0) | (lo3 << 12) | (mid3 << 16)
                | (h2 & 15) | ((h2 >> 4) << 8);
        end else if (code <= 19) begin
            tag = "R10";
            w = (((h >> 11) & 1) ? 32'hE59D0000 : 32'hE58D0000) | (r108 << 12) | (i8 << 2);
        end else if (code <= 21) begin
            tag = "R10";
            w = (((h >> 11) & 1) ? 32'hE28D0F00 : 32'hE28F0F00) | (r108 << 12) | i8;
        end else if (code <= 23) begin
            if (cc == 0) begin
                tag = "R10";
                w = (((h >> 7) & 1) ? 32'hE24DDF00 : 32'hE28DDF00) | (h & 127);
            end else begin
                tag = "R11";
                w = pp_b[(((h >> 11) & 1) << 1) | ((h >> 8) & 1)] | i8;
            end
        end else if (code <= 25) begin
            tag = "R11";
            w = (((h >> 11) & 1) ? 32'hE8B00000 : 32'hE8A00000) | (r108 << 16) | i8;
        end else if (code <= 27) begin
            if (cc == 15) begin
                tag = "R12";
                w = 32'hEF000000 | ((i8 == 24) ? (i8 << 16) : i8);
            end else if (cc == 14) st = 2'd1;
            else st = 2'd2;
        end else if (code == 29) begin
            st = 2'd1;
        end else begin
            st = 2'd2;
        end
    endfunction

    task automatic compare(input exp_t e);
        n_checks++;
        if (out_valid !== e.v || out_word !== e.w || out_status !== e.s) begin
            n_fails++;
            $display("FAIL %s half=%h: got v=%0d w=%h s=%0d, expected v=%0d w=%h s=%0d",
                     e.tag, e.h, out_valid, out_word, out_status, e.v, e.w, e.s);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] h);
        exp_t        e;
        logic [31:0] rw;
        logic [1:0]  rs;
        string       tg;
        @(negedge clk);
        if (pend.size() > 0) compare(pend.pop_front());
        in_valid = v;
        in_half  = h;
        if (v) begin
            ref_model(h, rw, rs, tg);
            hold_w = rw;
            hold_s = rs;
            e.tag  = tg;
        end else begin
            e.tag = "R13";
        end
        e.v = v;
        e.w = hold_w;
        e.s = hold_s;
        e.h = h;
        pend.push_back(e);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: ran %0d cycles, expected fewer", 200000);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        logic [15:0] dir [24] = '{16'h0000, 16'h1FFF, 16'h1A8B, 16'h2345, 16'h4340, 16'h4240,
                                  16'h4400, 16'h4778, 16'h46C0, 16'hDE00, 16'hDF18, 16'hDF17,
                                  16'hD0FF, 16'hE000, 16'hE800, 16'hF000, 16'hB000, 16'hB0FF,
                                  16'hB5FF, 16'hBD01, 16'h8FFF, 16'h7FFF, 16'h5E00, 16'hAFFF};
        logic [31:0] r;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_half  = 16'h0;
        repeat (2) @(negedge clk);
        // R13: reset state
        n_checks++;
        if (out_valid !== 1'b0 || out_word !== 32'h0 || out_status !== 2'd0) begin
            n_fails++;
            $display("FAIL R13 reset: got v=%0d w=%h s=%0d, expected v=0 w=00000000 s=0",
                     out_valid, out_word, out_status);
        end
        rst = 1'b0;

        foreach (dir[i]) begin
            step(1'b1, dir[i]);
            if (i % 3 == 2) step(1'b0, 16'hDF18); // idle input must not disturb outputs (R13)
        end
        // every format code
        for (int c = 0; c < 32; c++) begin
            for (int k = 0; k < 8; k++) begin
                r = $urandom;
                step(1'b1, {c[4:0], r[10:0]});
            end
        end
        // every register-operation and high-register op (R6, R7)
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 4; k++) begin
                r = $urandom;
                step(1'b1, {6'b010000, op[3:0], r[5:0]});
                step(1'b1, {6'b010001, op[3:0], r[11:6]});
            end
        end
        // every condition value (R1, R12)
        for (int cc = 0; cc < 16; cc++) begin
            r = $urandom;
            step(1'b1, {4'hD, cc[3:0], r[7:0]});
        end
        // random words with random idle cycles
        for (int n = 0; n < 4000; n++) begin
            r = $urandom;
            step(r[31:30] != 2'b00, r[15:0]);
        end
        step(1'b0, 16'h0);
        step(1'b0, 16'h0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule